// File: doc/BRIEF.md
# Single-Clock True Dual-Port RAM with Address-Collision Policy

This block is a synchronous storage array with two symmetric access ports, A and B, that share one clock. Each port has its own address, write data, write enable, read enable and a registered read-data output. Read data appears on the output one clock after the port samples its address and read enable. When a port's read enable is low, its output register keeps its last value.

The block states exactly what each output returns, and what the array stores, when the two ports reach the same address in the same cycle. Three elaboration parameters set these results. The first sets what a port returns when it writes and reads its own address. The second sets what a port returns when it reads an address that the other port is writing. The third sets what the array keeps when both ports write the same address. A value marked undefined is driven as all-X when `SIM_X` is set, and otherwise as the fixed word `DC_PAT`. A self-checking environment can therefore either mask these values or compare them exactly.

Collision handling applies only when both ports are active in the relevant way and their addresses are exactly equal. Accesses to different addresses never affect each other. Reset clears only the two output registers and leaves the array contents as they were.

Top module: `tdp_ram_collide`

## Requirements
- R1: A port whose read enable is low at a clock edge keeps its read-data output unchanged through that edge, whatever the other inputs do.
- R2: When both ports write the same address in one cycle, the array stores the undefined word (`DC_PAT`, or all-X with `SIM_X`=1) if `A_WINS`=0, and stores port A's write data if `A_WINS`=1.
- R3: With `SAME_MODE`=SP_NEW (0), a port that writes and reads in the same cycle outputs its own write data one cycle later.
- R4: With `SAME_MODE`=SP_DONTCARE (1), a port that writes and reads in the same cycle outputs the undefined word one cycle later.
- R5: With `MIX_MODE`=MX_FIRST (0), a port that reads (and does not write) an address the other port is writing outputs the writer's data if `MIX_FIRST_NEW`=1, and the undefined word if `MIX_FIRST_NEW`=0.
- R6: With `MIX_MODE`=MX_ASYM (1), port B reading an address that port A writes outputs the contents stored before the write, and port A reading an address that port B writes outputs port B's write data.
- R7: When both ports read the same address and neither writes, both outputs return the stored word and the array is left unchanged.
- R8: A write with no collision updates its location. Reads return data one cycle after the address is sampled, and accesses to different addresses are independent.
- R9: While the active-low asynchronous reset is asserted, both read-data outputs are zero. The array contents survive a reset.
- R10: The undefined word is all-X when `SIM_X`=1 and equals the parameter `DC_PAT` when `SIM_X`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_wr_en | input | 1 | Port A write enable |
| a_rd_en | input | 1 | Port A read enable |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_wr_en | input | 1 | Port B write enable |
| b_rd_en | input | 1 | Port B read enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The bound checker watches several rules on every cycle: the output hold when a read enable is low, the same-port result for the configured mode, the mixed-port result wherever the writer's data is what should appear, and the zero outputs during reset. Some results depend on earlier array contents and cannot be checked from a single cycle of port activity. These include a write collision stored as the undefined word or as port A's data, port B seeing the old word under the asymmetric mode, independent updates at different addresses, and array contents surviving reset. The bench's scenarios show these by reading the affected locations back later. Two instances with opposite parameter choices cover both branches of each mode.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  // Result of a port that writes and reads its own address in one cycle
  typedef enum logic {
    SP_NEW      = 1'b0,
    SP_DONTCARE = 1'b1
  } sp_mode_e;

  // Result of a port reading an address the other port is writing
  typedef enum logic {
    MX_FIRST = 1'b0,
    MX_ASYM  = 1'b1
  } mx_mode_e;

  // Source of the next read-data register value
  typedef enum logic [2:0] {
    SRC_HOLD  = 3'd0,
    SRC_MEM   = 3'd1,
    SRC_OWN   = 3'd2,
    SRC_OTHER = 3'd3,
    SRC_UNDEF = 3'd4
  } out_src_e;
endpackage

// File: rtl/tdp_collide_detect.sv
module tdp_collide_detect #(
  parameter int ADDR_W = 4
) (
  input  logic              a_wr_en,
  input  logic              a_rd_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_wr_en,
  input  logic              b_rd_en,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              wr_wr_hit,
  output logic              a_sees_b_wr,
  output logic              b_sees_a_wr
);
  logic addr_match;

  always_comb begin
    addr_match  = (a_addr == b_addr);
    wr_wr_hit   = a_wr_en & b_wr_en & addr_match;
    a_sees_b_wr = a_rd_en & ~a_wr_en & b_wr_en & addr_match;
    b_sees_a_wr = b_rd_en & ~b_wr_en & a_wr_en & addr_match;
  end
endmodule

// File: rtl/tdp_storage.sv
module tdp_storage #(
  parameter int              DATA_W = 16,
  parameter int              ADDR_W = 4,
  parameter bit              A_WINS = 1'b0,
  parameter bit              SIM_X  = 1'b0,
  parameter logic [DATA_W-1:0] DC_PAT = '0
) (
  input  logic              clk,
  input  logic              a_wr_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_wr_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              wr_wr_hit,
  output logic [DATA_W-1:0] a_old,
  output logic [DATA_W-1:0] b_old
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] UNDEF_W = SIM_X ? {DATA_W{1'bx}} : DC_PAT;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] clash_word;

  generate
    if (A_WINS) begin : g_a_prio
      assign clash_word = a_wdata;
    end else begin : g_corrupt
      assign clash_word = UNDEF_W;
    end
  endgenerate

  // Array has no reset: contents survive the output-register reset
  always_ff @(posedge clk) begin
    if (wr_wr_hit) begin
      mem[a_addr] <= clash_word;
    end else begin
      if (a_wr_en) mem[a_addr] <= a_wdata;
      if (b_wr_en) mem[b_addr] <= b_wdata;
    end
  end

  always_comb begin
    a_old = mem[a_addr];
    b_old = mem[b_addr];
  end
endmodule

// File: rtl/tdp_port_out.sv
module tdp_port_out
  import tdp_pkg::*;
#(
  parameter int              DATA_W        = 16,
  parameter bit              IS_A          = 1'b1,
  parameter sp_mode_e        SAME_MODE     = SP_NEW,
  parameter mx_mode_e        MIX_MODE      = MX_FIRST,
  parameter bit              MIX_FIRST_NEW = 1'b1,
  parameter bit              SIM_X         = 1'b0,
  parameter logic [DATA_W-1:0] DC_PAT      = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] own_wdata,
  input  logic [DATA_W-1:0] other_wdata,
  input  logic [DATA_W-1:0] mem_old,
  input  logic              sees_other_wr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] UNDEF_W = SIM_X ? {DATA_W{1'bx}} : DC_PAT;

  out_src_e          src;
  logic [DATA_W-1:0] rdata_nxt;
  logic              rdata_en;

  // Next-state: pick the source for the output register
  always_comb begin
    src = SRC_HOLD;
    if (rd_en) begin
      if (wr_en) begin
        src = (SAME_MODE == SP_NEW) ? SRC_OWN : SRC_UNDEF;
      end else if (sees_other_wr) begin
        if (MIX_MODE == MX_FIRST) begin
          src = MIX_FIRST_NEW ? SRC_OTHER : SRC_UNDEF;
        end else begin
          src = IS_A ? SRC_OTHER : SRC_MEM;
        end
      end else begin
        src = SRC_MEM;
      end
    end
  end

  always_comb begin
    rdata_en = (src != SRC_HOLD);
    unique case (src)
      SRC_MEM:   rdata_nxt = mem_old;
      SRC_OWN:   rdata_nxt = own_wdata;
      SRC_OTHER: rdata_nxt = other_wdata;
      SRC_UNDEF: rdata_nxt = UNDEF_W;
      default:   rdata_nxt = rdata;
    endcase
  end

  // Register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rdata_en) begin
      rdata <= rdata_nxt;
    end
  end
endmodule

// File: rtl/tdp_ram_collide.sv
module tdp_ram_collide
  import tdp_pkg::*;
#(
  parameter int              DATA_W        = 16,
  parameter int              ADDR_W        = 4,
  parameter sp_mode_e        SAME_MODE     = SP_NEW,
  parameter mx_mode_e        MIX_MODE      = MX_FIRST,
  parameter bit              MIX_FIRST_NEW = 1'b1,
  parameter bit              A_WINS        = 1'b0,
  parameter bit              SIM_X         = 1'b0,
  parameter logic [DATA_W-1:0] DC_PAT      = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr_en,
  input  logic              a_rd_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_wr_en,
  input  logic              b_rd_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int NPORT = 2;

  logic              wr_wr_hit;
  logic              a_sees_b_wr;
  logic              b_sees_a_wr;
  logic [DATA_W-1:0] a_old;
  logic [DATA_W-1:0] b_old;

  logic [NPORT-1:0]  p_wr;
  logic [NPORT-1:0]  p_rd;
  logic [NPORT-1:0]  p_sees;
  logic [DATA_W-1:0] p_wd   [NPORT];
  logic [DATA_W-1:0] p_old  [NPORT];
  logic [DATA_W-1:0] p_rdat [NPORT];

  tdp_collide_detect #(.ADDR_W(ADDR_W)) u_detect (
    .a_wr_en     (a_wr_en),
    .a_rd_en     (a_rd_en),
    .a_addr      (a_addr),
    .b_wr_en     (b_wr_en),
    .b_rd_en     (b_rd_en),
    .b_addr      (b_addr),
    .wr_wr_hit   (wr_wr_hit),
    .a_sees_b_wr (a_sees_b_wr),
    .b_sees_a_wr (b_sees_a_wr)
  );

  tdp_storage #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .A_WINS (A_WINS),
    .SIM_X  (SIM_X),
    .DC_PAT (DC_PAT)
  ) u_store (
    .clk       (clk),
    .a_wr_en   (a_wr_en),
    .a_addr    (a_addr),
    .a_wdata   (a_wdata),
    .b_wr_en   (b_wr_en),
    .b_addr    (b_addr),
    .b_wdata   (b_wdata),
    .wr_wr_hit (wr_wr_hit),
    .a_old     (a_old),
    .b_old     (b_old)
  );

  always_comb begin
    p_wr   = {b_wr_en, a_wr_en};
    p_rd   = {b_rd_en, a_rd_en};
    p_sees = {b_sees_a_wr, a_sees_b_wr};
    p_wd[0]  = a_wdata;
    p_wd[1]  = b_wdata;
    p_old[0] = a_old;
    p_old[1] = b_old;
  end

  generate
    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
      tdp_port_out #(
        .DATA_W        (DATA_W),
        .IS_A          (gp == 0),
        .SAME_MODE     (SAME_MODE),
        .MIX_MODE      (MIX_MODE),
        .MIX_FIRST_NEW (MIX_FIRST_NEW),
        .SIM_X         (SIM_X),
        .DC_PAT        (DC_PAT)
      ) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (p_wr[gp]),
        .rd_en         (p_rd[gp]),
        .own_wdata     (p_wd[gp]),
        .other_wdata   (p_wd[NPORT-1-gp]),
        .mem_old       (p_old[gp]),
        .sees_other_wr (p_sees[gp]),
        .rdata         (p_rdat[gp])
      );
    end
  endgenerate

  assign a_rdata = p_rdat[0];
  assign b_rdata = p_rdat[1];
endmodule

// File: rtl/tdp_ram_collide_chk.sv
module tdp_ram_collide_chk
  import tdp_pkg::*;
#(
  parameter int              DATA_W        = 16,
  parameter int              ADDR_W        = 4,
  parameter sp_mode_e        SAME_MODE     = SP_NEW,
  parameter mx_mode_e        MIX_MODE      = MX_FIRST,
  parameter bit              MIX_FIRST_NEW = 1'b1,
  parameter bit              SIM_X         = 1'b0,
  parameter logic [DATA_W-1:0] DC_PAT      = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_wr_en,
  input logic              a_rd_en,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_wdata,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_wr_en,
  input logic              b_rd_en,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic [DATA_W-1:0] b_rdata
);
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd_en |=> $stable(a_rdata)); // R1
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rd_en |=> $stable(b_rdata)); // R1

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_CLEAR: assert (a_rdata == '0 && b_rdata == '0); // R9
    end
  end

  generate
    if (SAME_MODE == SP_NEW) begin : g_sp_new
      AST_SAME_NEW_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_en && a_wr_en) |=> (a_rdata == $past(a_wdata))); // R3
      AST_SAME_NEW_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd_en && b_wr_en) |=> (b_rdata == $past(b_wdata))); // R3
    end else if (!SIM_X) begin : g_sp_dc
      AST_SAME_UNDEF_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_en && a_wr_en) |=> (a_rdata == DC_PAT)); // R4
      AST_SAME_UNDEF_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd_en && b_wr_en) |=> (b_rdata == DC_PAT)); // R4
    end

    if (MIX_MODE == MX_FIRST && MIX_FIRST_NEW) begin : g_mx_new
      AST_MIX_NEW_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_en && !a_wr_en && b_wr_en && a_addr == b_addr)
        |=> (a_rdata == $past(b_wdata))); // R5
      AST_MIX_NEW_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd_en && !b_wr_en && a_wr_en && a_addr == b_addr)
        |=> (b_rdata == $past(a_wdata))); // R5
    end else if (MIX_MODE == MX_ASYM) begin : g_mx_asym
      AST_MIX_ASYM_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_en && !a_wr_en && b_wr_en && a_addr == b_addr)
        |=> (a_rdata == $past(b_wdata))); // R6
    end
  endgenerate
endmodule

bind tdp_ram_collide tdp_ram_collide_chk #(
  .DATA_W        (DATA_W),
  .ADDR_W        (ADDR_W),
  .SAME_MODE     (SAME_MODE),
  .MIX_MODE      (MIX_MODE),
  .MIX_FIRST_NEW (MIX_FIRST_NEW),
  .SIM_X         (SIM_X),
  .DC_PAT        (DC_PAT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_wr_en (a_wr_en),
  .a_rd_en (a_rd_en),
  .a_addr  (a_addr),
  .a_wdata (a_wdata),
  .a_rdata (a_rdata),
  .b_wr_en (b_wr_en),
  .b_rd_en (b_rd_en),
  .b_addr  (b_addr),
  .b_wdata (b_wdata),
  .b_rdata (b_rdata)
);

// File: tb/tdp_ram_collide_tb.sv
module tdp_ram_collide_tb;
  import tdp_pkg::*;

  localparam int CLK_P = 10;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam logic [DW-1:0] UND = 16'hDEAD;

  typedef struct packed {
    logic          awe;
    logic          are;
    logic [AW-1:0] aad;
    logic [DW-1:0] awd;
    logic          bwe;
    logic          bre;
    logic [AW-1:0] bad;
    logic [DW-1:0] bwd;
    logic [DW-1:0] ea;
    logic [DW-1:0] eb;
  } vec_t;

  // Expected values are for u_dut: SP_NEW, MX_FIRST with writer data, corrupt on clash
  localparam vec_t VECS [12] = '{
    '{1'b1,1'b0,4'd1,16'h1111, 1'b1,1'b0,4'd2,16'h2222, 16'h0000,16'h0000}, // R8 writes, R1 hold
    '{1'b0,1'b1,4'd1,16'h0000, 1'b0,1'b1,4'd2,16'h0000, 16'h1111,16'h2222}, // R8 independent reads
    '{1'b0,1'b1,4'd1,16'h0000, 1'b0,1'b1,4'd1,16'h0000, 16'h1111,16'h1111}, // R7 both read same
    '{1'b1,1'b1,4'd3,16'h3333, 1'b0,1'b0,4'd3,16'h0000, 16'h3333,16'h1111}, // R3 A new, R1 B hold
    '{1'b0,1'b1,4'd3,16'h0000, 1'b1,1'b0,4'd3,16'h4444, 16'h4444,16'h1111}, // R5 A sees B new
    '{1'b0,1'b1,4'd3,16'h0000, 1'b0,1'b1,4'd3,16'h0000, 16'h4444,16'h4444}, // R8 B stored
    '{1'b1,1'b0,4'd5,16'h5555, 1'b1,1'b0,4'd5,16'h6666, 16'h4444,16'h4444}, // R2 clash write
    '{1'b0,1'b1,4'd5,16'h0000, 1'b0,1'b1,4'd1,16'h0000, UND,     16'h1111}, // R2 R10 corrupt word
    '{1'b0,1'b1,4'd6,16'h0000, 1'b1,1'b1,4'd6,16'h7777, 16'h7777,16'h7777}, // R5 R3
    '{1'b0,1'b0,4'd6,16'h0000, 1'b0,1'b0,4'd6,16'h0000, 16'h7777,16'h7777}, // R1 both idle
    '{1'b1,1'b1,4'd7,16'h8888, 1'b1,1'b1,4'd7,16'h9999, 16'h8888,16'h9999}, // R3 same-port wins
    '{1'b0,1'b1,4'd7,16'h0000, 1'b0,1'b1,4'd7,16'h0000, UND,     UND     }  // R2 corrupt
  };

  logic          clk;
  logic          rst_n;
  logic          a_wr_en, a_rd_en, b_wr_en, b_rd_en;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic [DW-1:0] a_rdata, b_rdata, a_rdata2, b_rdata2;

  int total;
  int bad;

  tdp_ram_collide #(
    .DATA_W(DW), .ADDR_W(AW), .SAME_MODE(SP_NEW), .MIX_MODE(MX_FIRST),
    .MIX_FIRST_NEW(1'b1), .A_WINS(1'b0), .SIM_X(1'b0), .DC_PAT(UND)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  tdp_ram_collide #(
    .DATA_W(DW), .ADDR_W(AW), .SAME_MODE(SP_DONTCARE), .MIX_MODE(MX_ASYM),
    .MIX_FIRST_NEW(1'b0), .A_WINS(1'b1), .SIM_X(1'b0), .DC_PAT(UND)
  ) u_alt (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata2),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata2)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic awe, input logic are, input logic [AW-1:0] aad,
                       input logic [DW-1:0] awd, input logic bwe, input logic bre,
                       input logic [AW-1:0] bad_i, input logic [DW-1:0] bwd);
    a_wr_en = awe; a_rd_en = are; a_addr = aad; a_wdata = awd;
    b_wr_en = bwe; b_rd_en = bre; b_addr = bad_i; b_wdata = bwd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    a_wr_en = 1'b0; a_rd_en = 1'b0; a_addr = '0; a_wdata = '0;
    b_wr_en = 1'b0; b_rd_en = 1'b0; b_addr = '0; b_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset A", a_rdata, '0);
    check("R9 reset B", b_rdata, '0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      drive(VECS[i].awe, VECS[i].are, VECS[i].aad, VECS[i].awd,
            VECS[i].bwe, VECS[i].bre, VECS[i].bad, VECS[i].bwd);
      check($sformatf("vec%0d port A", i), a_rdata, VECS[i].ea);
      check($sformatf("vec%0d port B", i), b_rdata, VECS[i].eb);
    end

    // u_alt: port A priority kept 5555 and 8888 on clashes (R2)
    drive(1'b0, 1'b1, 4'd5, 16'h0, 1'b0, 1'b1, 4'd7, 16'h0);
    check("R2 A wins addr5", a_rdata2, 16'h5555);
    check("R2 A wins addr7", b_rdata2, 16'h8888);

    // A writes+reads addr1; B reads addr1: alt gives undefined (R4), B old (R6)
    drive(1'b1, 1'b1, 4'd1, 16'hAAAA, 1'b0, 1'b1, 4'd1, 16'h0);
    check("R4 same-port undefined", a_rdata2, UND);
    check("R6 B sees old", b_rdata2, 16'h1111);
    check("R5 B sees A new (u_dut)", b_rdata, 16'hAAAA);

    // A reads addr2 while B writes it: A sees B's data (R6)
    drive(1'b0, 1'b1, 4'd2, 16'h0, 1'b1, 1'b0, 4'd2, 16'hBBBB);
    check("R6 A sees B new", a_rdata2, 16'hBBBB);
    check("R1 B hold alt", b_rdata2, 16'h1111);

    drive(1'b0, 1'b1, 4'd1, 16'h0, 1'b0, 1'b1, 4'd2, 16'h0);
    check("R8 alt addr1", a_rdata2, 16'hAAAA);
    check("R8 alt addr2", b_rdata2, 16'hBBBB);

    // Reset mid-run: outputs zero, array retained (R9)
    a_rd_en = 1'b0; b_rd_en = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R9 mid reset A", a_rdata, '0);
    check("R9 mid reset B alt", b_rdata2, '0);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 4'd1, 16'h0, 1'b0, 1'b1, 4'd3, 16'h0);
    check("R9 array kept A", a_rdata, 16'hAAAA);
    check("R9 array kept B", b_rdata, 16'h4444);
    check("R9 array kept alt", a_rdata2, 16'hAAAA);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule